// File: doc/BRIEF.md
# Data Object Protocol Discovery Responder

This block sits behind a data object mailbox and serves the discovery protocol. A host uses discovery to list the data object protocols a function supports. When the mailbox has collected a complete request, it presents the first two header dwords, the index byte and the number of dwords actually received, together with a one-cycle valid strobe. One cycle later the block returns a verdict. The verdict is one of three outcomes:

- the request was a discovery request, and here is the three-dword response object to load into the read mailbox;
- the request belongs to another registered protocol, and here is the table position of the handler to forward it to;
- the request was rejected, and the mailbox should be cleared.

The supported protocols are fixed at elaboration in a parameter table of vendor-ID and object-type pairs. Position 0 of the reported list is always discovery itself, and table entries follow it shifted by one. The block produces the next index that the host uses to continue walking the list. That next index returns to 0 after the last protocol.

Top module: `dsc_responder`

## Requirements
- R1: While reset is asserted and after its release with no request, `out_valid` is 0.
- R2: Every cycle with `in_valid` high produces exactly one cycle of `out_valid` on the following clock. No `out_valid` appears in any other cycle, and back-to-back requests give back-to-back verdicts.
- R3: A header dword is decoded as a whole 32-bit word: vendor ID in bits 15:0, object type in bits 23:16, and bits 31:24 required to be zero. Discovery is vendor `STD_VID` with type 0x00. Any difference, including a nonzero reserved byte, means no match.
- R4: The declared length is the low 18 bits of the second header dword, with 0 meaning 262144 dwords; bits 31:18 are ignored. A request whose `in_count` differs from the declared length is rejected, whatever its protocol.
- R5: A discovery request that declares fewer than 3 dwords is rejected, even when `in_count` matches.
- R6: An accepted discovery request gives `out_status` = 1 (discovery). `out_dw0` = `{8'h00, 8'h00, STD_VID}`, `out_dw1` = 3, and `out_dw2` = `{next index[31:24], object type[23:16], vendor ID[15:0]}`.
- R7: Index 0 reports vendor `STD_VID` and type 0x00.
- R8: An index i with 1 <= i <= `NUM_PROT` reports the vendor ID and type of table entry i-1. Entry k sits at bits `[24k+15:24k]` (vendor) and `[24k+23:24k+16]` (type) of `PROT_TABLE`.
- R9: An index above `NUM_PROT` reports vendor 0xFFFF and type 0xFF.
- R10: The next index is i+1 truncated to 8 bits. It is 0 when i+1 equals `NUM_PROT`+1, the total count including discovery.
- R11: A rejected request gives `out_status` = 0, with `out_sel` and all three response dwords at zero.
- R12: A non-discovery header equal to a table entry, with a matching length, gives `out_status` = 2 (forward). `out_sel` is then the lowest matching table position, and the response dwords are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: a complete request is presented |
| in_hdr0 | input | 32 | First header dword (vendor ID, object type, reserved) |
| in_hdr1 | input | 32 | Second header dword (length in dwords, low 18 bits) |
| in_index | input | 8 | Index byte of a discovery request |
| in_count | input | 19 | Number of dwords actually received |
| out_valid | output | 1 | One-cycle strobe: verdict below is valid |
| out_status | output | 2 | 0 reject, 1 discovery response, 2 forward |
| out_sel | output | 8 | Table position of the handler when forwarding |
| out_dw0 | output | 32 | Response header dword 0 |
| out_dw1 | output | 32 | Response header dword 1 (length) |
| out_dw2 | output | 32 | Response payload: next index, type, vendor ID |

## Verification
The bench builds the block with `NUM_PROT` = 3, which puts both the final-entry wrap of the next index and the out-of-range indices within a few requests. Index 255 additionally exercises the 8-bit truncation of the next index. Entries 0 and 2 of the table carry the same pair. This makes the lowest-position priority of the forward selection observable, and index 3 reads a duplicate through a different path. Lengths of 0, 2 and 3, stray upper length bits and counts off by one reach every accept and reject branch of the length rules.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
   localparam int unsigned DWORD_W = 32;
   localparam int unsigned LEN_W   = 18;
   localparam int unsigned IDX_W   = 8;
   localparam int unsigned ENT_W   = 24;
   localparam logic [7:0]  DISC_TYPE = 8'h00;
   localparam logic [LEN_W:0] DISC_DWORDS = 19'd3;

   typedef enum logic [1:0] {
      ST_REJECT = 2'd0,
      ST_DISC   = 2'd1,
      ST_FWD    = 2'd2
   } dsc_status_e;

   function automatic logic [DWORD_W-1:0] hdr_word(input logic [15:0] vid,
                                                   input logic [7:0] typ);
      return {8'h00, typ, vid};
   endfunction
endpackage

// File: rtl/dsc_decode.sv
module dsc_decode
   import dsc_pkg::*;
#(
   parameter int unsigned NUM_PROT = 3,
   parameter logic [15:0] STD_VID = 16'h0001,
   parameter logic [NUM_PROT*ENT_W-1:0] PROT_TABLE = '0
) (
   input  logic [DWORD_W-1:0] hdr0,
   output logic               is_disc,
   output logic               hit,
   output logic [IDX_W-1:0]   sel
);
   logic [NUM_PROT-1:0] match;

   for (genvar k = 0; k < NUM_PROT; k++) begin : g_cmp
      assign match[k] = (hdr0 == hdr_word(PROT_TABLE[k*ENT_W +: 16],
                                          PROT_TABLE[k*ENT_W+16 +: 8]));
   end

   assign is_disc = (hdr0 == hdr_word(STD_VID, DISC_TYPE));
   assign hit     = |match;

   // lowest position wins: scan downward so the last write is the lowest
   always_comb begin
      sel = '0;
      for (int k = NUM_PROT - 1; k >= 0; k--) begin
         if (match[k]) sel = IDX_W'(k);
      end
   end
endmodule

// File: rtl/dsc_len_chk.sv
module dsc_len_chk
   import dsc_pkg::*;
(
   input  logic [DWORD_W-1:0] hdr1,
   input  logic [LEN_W:0]     count,
   output logic               len_match,
   output logic               len_min_ok
);
   logic [LEN_W:0] declared;
   logic           unused_hi;

   assign unused_hi = ^hdr1[DWORD_W-1:LEN_W];
   assign declared  = (hdr1[LEN_W-1:0] == '0) ? {1'b1, {LEN_W{1'b0}}}
                                              : {1'b0, hdr1[LEN_W-1:0]};
   assign len_match  = (declared == count);
   assign len_min_ok = (declared >= DISC_DWORDS);
endmodule

// File: rtl/dsc_lookup.sv
module dsc_lookup
   import dsc_pkg::*;
#(
   parameter int unsigned NUM_PROT = 3,
   parameter logic [15:0] STD_VID = 16'h0001,
   parameter logic [NUM_PROT*ENT_W-1:0] PROT_TABLE = '0
) (
   input  logic [IDX_W-1:0] idx,
   output logic [15:0]      vid,
   output logic [7:0]       typ,
   output logic [IDX_W-1:0] nxt
);
   localparam logic [IDX_W:0] TOTAL = (IDX_W+1)'(NUM_PROT + 1);

   logic [ENT_W-1:0] sel_ent;
   logic [ENT_W-1:0] fin_ent;
   logic [IDX_W:0]   inc;

   always_comb begin
      sel_ent = {DISC_TYPE, STD_VID};
      for (int k = 0; k < NUM_PROT; k++) begin
         if (idx == IDX_W'(k + 1)) sel_ent = PROT_TABLE[k*ENT_W +: ENT_W];
      end
   end

   if (NUM_PROT < 255) begin : g_oor
      assign fin_ent = (idx > IDX_W'(NUM_PROT)) ? '1 : sel_ent;
   end else begin : g_full
      assign fin_ent = sel_ent;
   end

   assign vid = fin_ent[15:0];
   assign typ = fin_ent[23:16];
   assign inc = {1'b0, idx} + 1'b1;
   assign nxt = (inc == TOTAL) ? '0 : inc[IDX_W-1:0];
endmodule

// File: rtl/dsc_responder.sv
module dsc_responder
   import dsc_pkg::*;
#(
   parameter int unsigned NUM_PROT = 3,
   parameter logic [15:0] STD_VID = 16'h0001,
   parameter logic [NUM_PROT*24-1:0] PROT_TABLE = {24'h05_BEEF, 24'h11_7B10, 24'h02_A5C3}
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [31:0] in_hdr0,
   input  logic [31:0] in_hdr1,
   input  logic [7:0]  in_index,
   input  logic [18:0] in_count,
   output logic        out_valid,
   output logic [1:0]  out_status,
   output logic [7:0]  out_sel,
   output logic [31:0] out_dw0,
   output logic [31:0] out_dw1,
   output logic [31:0] out_dw2
);
   if (NUM_PROT < 1 || NUM_PROT > 255) begin : g_bad_num
      $error("dsc_responder: NUM_PROT must lie in 1..255");
   end

   logic             is_disc, hit, len_match, len_min_ok;
   logic [IDX_W-1:0] hit_sel, nxt;
   logic [15:0]      lk_vid;
   logic [7:0]       lk_typ;
   dsc_status_e      st_d;

   dsc_decode #(.NUM_PROT(NUM_PROT), .STD_VID(STD_VID), .PROT_TABLE(PROT_TABLE))
   i_decode (.hdr0(in_hdr0), .is_disc(is_disc), .hit(hit), .sel(hit_sel));

   dsc_len_chk i_len (.hdr1(in_hdr1), .count(in_count),
                      .len_match(len_match), .len_min_ok(len_min_ok));

   dsc_lookup #(.NUM_PROT(NUM_PROT), .STD_VID(STD_VID), .PROT_TABLE(PROT_TABLE))
   i_lookup (.idx(in_index), .vid(lk_vid), .typ(lk_typ), .nxt(nxt));

   always_comb begin
      if (is_disc && len_match && len_min_ok) st_d = ST_DISC;
      else if (!is_disc && hit && len_match)  st_d = ST_FWD;
      else                                    st_d = ST_REJECT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_status <= ST_REJECT;
         out_sel    <= '0;
         out_dw0    <= '0;
         out_dw1    <= '0;
         out_dw2    <= '0;
      end else begin
         out_valid  <= in_valid;
         out_status <= st_d;
         out_sel    <= (st_d == ST_FWD) ? hit_sel : '0;
         if (st_d == ST_DISC) begin
            out_dw0 <= hdr_word(STD_VID, DISC_TYPE);
            out_dw1 <= 32'(DISC_DWORDS);
            out_dw2 <= {nxt, lk_typ, lk_vid};
         end else begin
            out_dw0 <= '0;
            out_dw1 <= '0;
            out_dw2 <= '0;
         end
      end
   end

   // R1 / R2: verdict strobe tracks the request strobe by one clock
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R6: discovery response header is fixed
   a_r6_disc_header: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == ST_DISC) |->
      (out_dw1 == 32'd3 && out_dw0 == {16'h0000, STD_VID}));
   // R9: out-of-range index yields all-ones identifiers
   a_r9_oor_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && int'(in_index) > int'(NUM_PROT)) |=>
      (out_status != ST_DISC || out_dw2[23:0] == 24'hFFFFFF));
   // R11: rejection carries no payload
   a_r11_reject_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == ST_REJECT) |->
      (out_dw0 == '0 && out_dw1 == '0 && out_dw2 == '0 && out_sel == '0));
   // R12: forward selection stays inside the table
   a_r12_fwd_range: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == ST_FWD) |->
      (int'(out_sel) < int'(NUM_PROT) && out_dw2 == '0));
endmodule

// File: tb/test_dsc_responder.sv
module test_dsc_responder;
   localparam int NP = 3;
   localparam logic [15:0] VID = 16'h0001;
   // entries 0 and 2 are identical on purpose
   localparam logic [NP*24-1:0] TBL = {24'h02_A5C3, 24'h11_7B10, 24'h02_A5C3};

   logic [15:0] t_vid [NP];
   logic [7:0]  t_typ [NP];
   initial begin
      t_vid[0] = 16'hA5C3; t_typ[0] = 8'h02;
      t_vid[1] = 16'h7B10; t_typ[1] = 8'h11;
      t_vid[2] = 16'hA5C3; t_typ[2] = 8'h02;
   end

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [31:0] in_hdr0 = '0, in_hdr1 = '0;
   logic [7:0]  in_index = '0;
   logic [18:0] in_count = '0;
   logic out_valid;
   logic [1:0] out_status;
   logic [7:0] out_sel;
   logic [31:0] out_dw0, out_dw1, out_dw2;

   always #5 clk = ~clk;

   dsc_responder #(.NUM_PROT(NP), .STD_VID(VID), .PROT_TABLE(TBL)) i_dsc_responder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hdr0(in_hdr0),
      .in_hdr1(in_hdr1), .in_index(in_index), .in_count(in_count),
      .out_valid(out_valid), .out_status(out_status), .out_sel(out_sel),
      .out_dw0(out_dw0), .out_dw1(out_dw1), .out_dw2(out_dw2));

   typedef struct packed {
      logic [1:0]  st;
      logic [7:0]  sel;
      logic [31:0] d0, d1, d2;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int checks = 0, errors = 0;
   bit done = 0;

   function automatic exp_t model(input logic [31:0] h0, input logic [31:0] h1,
                                  input logic [18:0] cnt, input logic [7:0] idx);
      exp_t e;
      int decl, fsel, n;
      bit lok, disc;
      e = '0;
      decl = (h1[17:0] == 0) ? 262144 : int'(h1[17:0]);
      lok  = (int'(cnt) == decl);
      disc = (h0 == {16'h0000, VID});
      fsel = -1;
      for (int k = NP - 1; k >= 0; k--)
         if (h0 == {8'h00, t_typ[k], t_vid[k]}) fsel = k;
      if (disc && lok && decl >= 3) begin
         e.st = 2'd1;
         e.d0 = {16'h0000, VID};
         e.d1 = 32'd3;
         n = int'(idx) + 1;
         if (n == NP + 1) n = 0;
         if (idx == 0)              e.d2[23:0] = {8'h00, VID};
         else if (int'(idx) <= NP)  e.d2[23:0] = {t_typ[idx-1], t_vid[idx-1]};
         else                       e.d2[23:0] = 24'hFFFFFF;
         e.d2[31:24] = n[7:0];
      end else if (!disc && fsel >= 0 && lok) begin
         e.st  = 2'd2;
         e.sel = fsel[7:0];
      end
      return e;
   endfunction

   task automatic send(input logic [31:0] h0, input logic [31:0] h1,
                       input logic [18:0] cnt, input logic [7:0] idx, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_hdr0 = h0; in_hdr1 = h1; in_count = cnt; in_index = idx;
      exp_q.push_back(model(h0, h1, cnt, idx));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         exp_t e;
         string t;
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2: unexpected out_valid (actual 1, expected 0)");
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({out_status, out_sel, out_dw0, out_dw1, out_dw2} != e) begin
               errors++;
               $display("FAIL %s: actual st=%0d sel=%0d %h %h %h expected st=%0d sel=%0d %h %h %h",
                        t, out_status, out_sel, out_dw0, out_dw1, out_dw2,
                        e.st, e.sel, e.d0, e.d1, e.d2);
            end
         end
      end
   end

   localparam logic [31:0] DH = {16'h0000, VID};

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid in reset actual %b expected 0", out_valid);
      end
      rst_n = 1'b1;
      idle(2);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1: out_valid after reset actual %b expected 0", out_valid);
      end
      send(DH, 32'd3, 19'd3, 8'd0,   "R7_R6_R10 index0");
      idle(1);
      send(DH, 32'd3, 19'd3, 8'd1,   "R8 index1");
      send(DH, 32'd3, 19'd3, 8'd2,   "R8_R2 index2 back-to-back");
      send(DH, 32'd3, 19'd3, 8'd3,   "R10 last entry wraps");
      send(DH, 32'd3, 19'd3, 8'd4,   "R9 index past end");
      send(DH, 32'd3, 19'd3, 8'd255, "R9_R10 index 255");
      idle(2);
      send(DH, 32'd2, 19'd2, 8'd0,   "R5 short discovery");
      send(DH, 32'd3, 19'd4, 8'd0,   "R4 count mismatch");
      send(DH, 32'hFFFC_0003, 19'd3, 8'd1, "R4 upper length bits ignored");
      send(DH, 32'd0, 19'd262144, 8'd2, "R4 zero length is max");
      send(DH, 32'd0, 19'd3, 8'd0,   "R4 zero length vs 3 received");
      send(32'h0002_A5C3, 32'd5, 19'd5, 8'd0, "R12 forward lowest position");
      send(32'h0011_7B10, 32'd7, 19'd7, 8'd9, "R12 forward entry1");
      send(32'h0011_7B10, 32'd7, 19'd6, 8'd0, "R4_R11 forward length mismatch");
      send(32'h0033_4444, 32'd3, 19'd3, 8'd0, "R11 unknown header");
      send(32'h0100_0001, 32'd3, 19'd3, 8'd0, "R3 reserved byte set");
      send(32'h0001_0001, 32'd3, 19'd3, 8'd0, "R3 wrong type");
      idle(4);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2: missing verdicts actual %0d pending expected 0", exp_q.size());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL R2: watchdog expired (actual hung, expected completion)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule